// File: doc/BRIEF.md
# Triggered One-Shot ADC Sequencer

This block is the digital control sequencer for an A/D converter that runs one conversion on one selected channel each time a hardware trigger arrives. Software sees three register-style controls: an enable level, a conversion-status bit that software can write, and a channel-select field. While enabled and idle, the block waits in trigger standby. A trigger starts a settling wait and then a fixed run of conversion cycles. At the end, the sample for the latched channel is captured into the result register and a one-cycle completion pulse is raised.

The converter itself is modelled digitally. Each channel drives a lane of a flat sample bus, and the lane picked by the latched channel is captured on the final conversion cycle. While a conversion runs, a new trigger, any write to the channel field or a write of 1 to the status bit throws the partial work away and starts again from the settling wait. A write of 0 to the status bit, or dropping the enable, abandons the conversion and produces neither a result nor a pulse.

Top module: `adc_oneshot_seq`

## Requirements
- R1: After reset `busy_o`, `done_o`, `result_o` and `chan_o` are all 0.
- R2: While `en_i` is 0, a pulse on `trig_i` starts nothing: `busy_o` stays 0 and no `done_o` appears.
- R3: With `en_i` at 1 and the block idle, a trigger at clock edge E sets `busy_o` to 1 after E and latches the current channel field, or the value written in that same cycle.
- R4: A conversion started at edge E completes at edge E+STAB_CYC+CONV_CYC. After that edge `result_o` holds lane `k` of `sample_i` (bits `k*DATA_W` upward, where `k` is the latched channel), `done_o` is 1 for exactly one cycle and `busy_o` is 0.
- R5: A trigger during a conversion restarts it on the same channel. Timing is counted again from the restart edge, and `result_o` does not change and `done_o` stays 0 until the restarted conversion ends.
- R6: A write to the channel field during a conversion restarts it on the written channel, even when the written value equals the current one.
- R7: Writing 1 to the status bit while `busy_o` is 1 restarts the conversion with fresh timing.
- R8: Writing 0 to the status bit while `busy_o` is 1 aborts the conversion. `busy_o` is 0 on the next cycle, no `done_o` follows and `result_o` is unchanged. A later trigger starts normally.
- R9: Writing 1 to the status bit while idle has no effect, and `busy_o` stays 0.
- R10: A status-bit write of 0 in the same cycle as a trigger wins over the trigger, and `busy_o` is 0 after that edge.
- R11: Lowering `en_i` during a conversion aborts it in the same way as R8.
- R12: A channel write while idle updates `chan_o` and selects the lane for the next triggered conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Converter enable level |
| trig_i | input | 1 | Hardware trigger, sampled each cycle |
| start_wr_i | input | 1 | Write strobe for the status bit |
| start_wdata_i | input | 1 | Value written to the status bit |
| chan_wr_i | input | 1 | Write strobe for the channel field |
| chan_wdata_i | input | CH_W | Value written to the channel field |
| sample_i | input | NUM_CH*DATA_W | Per-channel sample lanes, with channel k at bits k*DATA_W upward |
| busy_o | output | 1 | Conversion-status bit: 1 while settling or converting |
| chan_o | output | CH_W | Current channel field |
| result_o | output | DATA_W | Last completed conversion result |
| done_o | output | 1 | One-cycle conversion-end pulse |

## Verification
Two collisions need deliberate testing. The first is a trigger and a clearing write to the status bit in the same cycle. The bench drives both in one cycle, both during a conversion and from idle. It expects `busy_o` low afterwards, and the scoreboard flags any completion pulse that was not queued. The second is a channel write and a trigger in the same idle cycle. The bench expects the queued result to come from the newly written lane, at a completion cycle counted from that shared edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int DEF_DATA_W   = 10;
    localparam int DEF_NUM_CH   = 4;
    localparam int DEF_STAB_CYC = 4;
    localparam int DEF_CONV_CYC = 6;

    // Sequencer phase: stopped, settling wait, or conversion cycles
    typedef enum logic [1:0] {
        PH_STOP    = 2'd0,
        PH_SETTLE  = 2'd1,
        PH_CONVERT = 2'd2
    } phase_e;

    // Requests produced by the arbitration logic each cycle
    typedef struct packed {
        logic abort;
        logic restart;
        logic launch;
        logic finish;
    } seq_req_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int width_for(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/adc_seq_mux.sv
module adc_seq_mux
    import adc_seq_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int CH_W   = width_for(NUM_CH)
) (
    input  logic [NUM_CH*DATA_W-1:0] sample_i,
    input  logic [CH_W-1:0]          sel_i,
    output logic [DATA_W-1:0]        data_o
);

    logic [DATA_W-1:0] lane [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        assign lane[g] = sample_i[g*DATA_W +: DATA_W];
    end

    always_comb begin
        data_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (int'(sel_i) == i) begin
                data_o = lane[i];
            end
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CH_W     = 2,
    parameter int STAB_CYC = DEF_STAB_CYC,
    parameter int CONV_CYC = DEF_CONV_CYC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en_i,
    input  logic            trig_i,
    input  logic            start_wr_i,
    input  logic            start_wdata_i,
    input  logic            chan_wr_i,
    input  logic [CH_W-1:0] chan_wdata_i,
    output logic            busy_o,
    output logic [CH_W-1:0] chan_o,
    output logic [CH_W-1:0] conv_ch_o,
    output logic            finish_o
);

    localparam int CNT_W = width_for(max2(STAB_CYC, CONV_CYC) + 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST  = CNT_W'(STAB_CYC - 1);
    localparam logic [CNT_W-1:0] CONVERT_LAST = CNT_W'(CONV_CYC - 1);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CH_W-1:0]  chan_q;
    logic [CH_W-1:0]  conv_ch_q;

    logic            active;
    logic            clear_wr;
    logic            set_wr;
    logic [CH_W-1:0] chan_next;
    seq_req_t        req;

    always_comb begin
        active    = (phase_q != PH_STOP);
        clear_wr  = start_wr_i && !start_wdata_i;
        set_wr    = start_wr_i &&  start_wdata_i;
        chan_next = chan_wr_i ? chan_wdata_i : chan_q;

        // Priority: abort beats restart, restart beats normal completion
        req.abort   = active && (clear_wr || !en_i);
        req.restart = active && !req.abort && (trig_i || chan_wr_i || set_wr);
        req.launch  = !active && en_i && trig_i && !clear_wr;
        req.finish  = (phase_q == PH_CONVERT) && (cnt_q == CONVERT_LAST)
                      && !req.abort && !req.restart;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_STOP;
            cnt_q     <= '0;
            chan_q    <= '0;
            conv_ch_q <= '0;
        end else begin
            chan_q <= chan_next;
            if (req.abort) begin
                phase_q <= PH_STOP;
                cnt_q   <= '0;
            end else if (req.restart || req.launch) begin
                phase_q   <= PH_SETTLE;
                cnt_q     <= '0;
                conv_ch_q <= chan_next;
            end else begin
                unique case (phase_q)
                    PH_SETTLE: begin
                        if (cnt_q == SETTLE_LAST) begin
                            phase_q <= PH_CONVERT;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_CONVERT: begin
                        if (cnt_q == CONVERT_LAST) begin
                            phase_q <= PH_STOP;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: begin
                        phase_q <= PH_STOP;
                        cnt_q   <= '0;
                    end
                endcase
            end
        end
    end

    assign busy_o    = active;
    assign chan_o    = chan_q;
    assign conv_ch_o = conv_ch_q;
    assign finish_o  = req.finish;

endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result
    import adc_seq_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              finish_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] result_o,
    output logic              done_o
);

    logic [DATA_W-1:0] result_q;
    logic              done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= finish_i;
            if (finish_i) begin
                result_q <= data_i;
            end
        end
    end

    assign result_o = result_q;
    assign done_o   = done_q;

endmodule

// File: rtl/adc_oneshot_seq.sv
module adc_oneshot_seq
    import adc_seq_pkg::*;
#(
    parameter int DATA_W   = DEF_DATA_W,
    parameter int NUM_CH   = DEF_NUM_CH,
    parameter int STAB_CYC = DEF_STAB_CYC,
    parameter int CONV_CYC = DEF_CONV_CYC,
    parameter int CH_W     = width_for(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en_i,
    input  logic                     trig_i,
    input  logic                     start_wr_i,
    input  logic                     start_wdata_i,
    input  logic                     chan_wr_i,
    input  logic [CH_W-1:0]          chan_wdata_i,
    input  logic [NUM_CH*DATA_W-1:0] sample_i,
    output logic                     busy_o,
    output logic [CH_W-1:0]          chan_o,
    output logic [DATA_W-1:0]        result_o,
    output logic                     done_o
);

    logic [CH_W-1:0]   conv_ch;
    logic              finish;
    logic [DATA_W-1:0] lane_data;

    adc_seq_ctrl #(
        .CH_W     (CH_W),
        .STAB_CYC (STAB_CYC),
        .CONV_CYC (CONV_CYC)
    ) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .en_i          (en_i),
        .trig_i        (trig_i),
        .start_wr_i    (start_wr_i),
        .start_wdata_i (start_wdata_i),
        .chan_wr_i     (chan_wr_i),
        .chan_wdata_i  (chan_wdata_i),
        .busy_o        (busy_o),
        .chan_o        (chan_o),
        .conv_ch_o     (conv_ch),
        .finish_o      (finish)
    );

    adc_seq_mux #(
        .DATA_W (DATA_W),
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_mux (
        .sample_i (sample_i),
        .sel_i    (conv_ch),
        .data_o   (lane_data)
    );

    adc_seq_result #(
        .DATA_W (DATA_W)
    ) u_result (
        .clk      (clk),
        .rst      (rst),
        .finish_i (finish),
        .data_i   (lane_data),
        .result_o (result_o),
        .done_o   (done_o)
    );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              en_i,
    input logic              trig_i,
    input logic              start_wr_i,
    input logic              start_wdata_i,
    input logic              busy_o,
    input logic [DATA_W-1:0] result_o,
    input logic              done_o
);

    // R2
    trig_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !busy_o && trig_i) |=> !busy_o);

    // R3
    trig_launch_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i && !busy_o && trig_i && !(start_wr_i && !start_wdata_i)) |=> busy_o);

    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(result_o));

    // R8
    clear_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_wr_i && !start_wdata_i) |=> (!busy_o && !done_o));

    // R9
    idle_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_wr_i && start_wdata_i && !trig_i) |=> !busy_o);

    // R10
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (start_wr_i && !start_wdata_i && trig_i) |=> !busy_o);

    // R11
    disable_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !en_i) |=> (!busy_o && !done_o));

endmodule

bind adc_oneshot_seq adc_seq_chk #(.DATA_W(DATA_W)) i_chk (
    .clk           (clk),
    .rst           (rst),
    .en_i          (en_i),
    .trig_i        (trig_i),
    .start_wr_i    (start_wr_i),
    .start_wdata_i (start_wdata_i),
    .busy_o        (busy_o),
    .result_o      (result_o),
    .done_o        (done_o)
);

// File: tb/test_adc_oneshot_seq.sv
module test_adc_oneshot_seq;

    localparam int CLK_PERIOD = 10;
    localparam int DW   = 10;
    localparam int NCH  = 4;
    localparam int CW   = 2;
    localparam int STAB = 4;
    localparam int CONV = 6;
    localparam int LAT  = STAB + CONV;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   en_i = 1'b0;
    logic                   trig_i = 1'b0;
    logic                   start_wr_i = 1'b0;
    logic                   start_wdata_i = 1'b0;
    logic                   chan_wr_i = 1'b0;
    logic [CW-1:0]          chan_wdata_i = '0;
    logic [NCH-1:0][DW-1:0] smp;
    logic                   busy_o;
    logic [CW-1:0]          chan_o;
    logic [DW-1:0]          result_o;
    logic                   done_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [DW-1:0] data;
        int            at;
        string         tag;
    } exp_t;
    exp_t sb[$];

    adc_oneshot_seq #(
        .DATA_W(DW), .NUM_CH(NCH), .STAB_CYC(STAB), .CONV_CYC(CONV)
    ) i_adc_oneshot_seq (
        .clk(clk), .rst(rst), .en_i(en_i), .trig_i(trig_i),
        .start_wr_i(start_wr_i), .start_wdata_i(start_wdata_i),
        .chan_wr_i(chan_wr_i), .chan_wdata_i(chan_wdata_i),
        .sample_i(smp), .busy_o(busy_o), .chan_o(chan_o),
        .result_o(result_o), .done_o(done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Driver side: queue a result expected LAT edges after the edge following cycle c
    task automatic expect_result(input int lane, input int c, input string tag);
        exp_t e;
        e.data = smp[lane];
        e.at   = c + 1 + LAT;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input bit t, input bit sw, input bit sd,
                         input bit cw, input logic [CW-1:0] cd, output int c);
        c = cyc;
        trig_i = t; start_wr_i = sw; start_wdata_i = sd;
        chan_wr_i = cw; chan_wdata_i = cd;
        @(negedge clk);
        trig_i = 0; start_wr_i = 0; start_wdata_i = 0; chan_wr_i = 0;
    endtask

    // Monitor: every completion pulse must match the head of the scoreboard
    always @(negedge clk) begin
        if (!rst && done_o) begin
            if (sb.size() == 0) begin
                check(0, "R8 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(result_o == e.data, e.tag, result_o, e.data);
                check(cyc == e.at, {e.tag, " timing"}, cyc, e.at);
                check(!busy_o, {e.tag, " busy after done"}, busy_o, 0);
            end
        end
    end

    initial begin
        int c;
        smp[0] = 10'h011; smp[1] = 10'h122; smp[2] = 10'h233; smp[3] = 10'h3c4;
        ticks(3);
        rst = 0;
        ticks(1);
        // R1
        check(busy_o == 0 && done_o == 0, "R1 busy/done", {busy_o, done_o}, 0);
        check(result_o == 0, "R1 result", result_o, 0);
        check(chan_o == 0, "R1 chan", chan_o, 0);

        // R2: trigger while disabled
        pulse(1, 0, 0, 0, 0, c);
        check(busy_o == 0, "R2 busy", busy_o, 0);
        ticks(LAT + 2);
        check(busy_o == 0, "R2 still idle", busy_o, 0);

        // R12: idle channel write
        en_i = 1;
        pulse(0, 0, 0, 1, 2'd1, c);
        check(chan_o == 1, "R12 chan field", chan_o, 1);
        check(busy_o == 0, "R12 no start", busy_o, 0);

        // R3/R4: basic conversion on lane 1
        pulse(1, 0, 0, 0, 0, c);
        expect_result(1, c, "R4 lane1");
        check(busy_o == 1, "R3 busy set", busy_o, 1);
        ticks(LAT + 2);
        check(sb.size() == 0, "R4 completed", sb.size(), 0);

        // R5: trigger during conversion
        smp[1] = 10'h155;
        pulse(1, 0, 0, 0, 0, c);
        ticks(3);
        pulse(1, 0, 0, 0, 0, c);
        expect_result(1, c, "R5 restart");
        ticks(LAT - 3);
        check(result_o == 10'h122, "R5 result held", result_o, 10'h122);
        ticks(6);
        check(sb.size() == 0, "R5 completed", sb.size(), 0);

        // R6: channel rewrite during conversion (new value, then same value)
        pulse(1, 0, 0, 0, 0, c);
        ticks(5);
        pulse(0, 0, 0, 1, 2'd2, c);
        expect_result(2, c, "R6 new chan");
        ticks(LAT + 2);
        pulse(1, 0, 0, 0, 0, c);
        ticks(2);
        pulse(0, 0, 0, 1, 2'd2, c);
        expect_result(2, c, "R6 same chan");
        ticks(LAT + 2);
        check(sb.size() == 0, "R6 completed", sb.size(), 0);

        // R7: writing 1 to the status bit while busy
        smp[2] = 10'h2aa;
        pulse(1, 0, 0, 0, 0, c);
        ticks(4);
        pulse(0, 1, 1, 0, 0, c);
        expect_result(2, c, "R7 restart");
        ticks(LAT + 2);
        check(sb.size() == 0, "R7 completed", sb.size(), 0);

        // R8: clearing the status bit aborts
        pulse(1, 0, 0, 0, 0, c);
        ticks(6);
        pulse(0, 1, 0, 0, 0, c);
        check(busy_o == 0, "R8 busy cleared", busy_o, 0);
        ticks(LAT + 2);
        check(result_o == 10'h2aa, "R8 result kept", result_o, 10'h2aa);
        pulse(1, 0, 0, 0, 0, c);
        expect_result(2, c, "R8 next trigger");
        ticks(LAT + 2);

        // R9: status write 1 while idle
        pulse(0, 1, 1, 0, 0, c);
        check(busy_o == 0, "R9 idle set ignored", busy_o, 0);

        // R10: clear and trigger in the same cycle, busy and idle
        pulse(1, 0, 0, 0, 0, c);
        ticks(3);
        pulse(1, 1, 0, 0, 0, c);
        check(busy_o == 0, "R10 clear wins busy", busy_o, 0);
        pulse(1, 1, 0, 0, 0, c);
        check(busy_o == 0, "R10 clear wins idle", busy_o, 0);
        ticks(LAT + 2);

        // R11: dropping enable aborts
        pulse(1, 0, 0, 0, 0, c);
        ticks(3);
        en_i = 0;
        ticks(1);
        check(busy_o == 0, "R11 disable abort", busy_o, 0);
        ticks(LAT + 2);
        en_i = 1;

        // R3/R12: channel write and trigger in the same idle cycle
        pulse(1, 0, 0, 1, 2'd3, c);
        expect_result(3, c, "R3 same-cycle chan");
        check(chan_o == 3, "R12 chan updated", chan_o, 3);
        ticks(LAT + 2);
        check(sb.size() == 0, "R4 scoreboard drained", sb.size(), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule